// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Pulse Generator

The block derives two gate-drive waveforms from a single fast reference clock. A modulo counter splits the reference clock into one output period. Decoded counter states then set and clear a registered flop for each output. Every edge therefore lands at a fixed fraction of the period, and the two pulses keep the same phase relation when the reference frequency is swept.

Phase A is high for the first 45% of each period. Phase B is high from 55% to 90% of the period, so it lies wholly inside the low time of phase A. There is a 10% guard gap on each side of phase B.

A build parameter picks one of two counter variants:
- **Linear mode** (default) uses 100 steps per period. With a 100 kHz to 100 MHz reference clock this gives 1 kHz to 1 MHz outputs.
- **Decade mode** uses 20 steps per period (5% per step). Its counter is a 0–9 decade with a half-period toggle that flips on each decade wrap.

A one-cycle strobe marks each return of the counter to zero.

Top module: `twophase_gen`

## Requirements
- R1: Phase A is high for exactly 45% of the period, as consecutive cycles: 45 cycles in linear mode and 9 in decade mode. It rises one cycle after the counter passes position 0 and falls one cycle after position 45% (count 45 or 9).
- R2: Phase B is high for exactly 35% of the period: 35 cycles in linear mode and 7 in decade mode. It is set after position 55% (count 55 or 11) and cleared after position 90% (count 90 or 18).
- R3: The two phases are never high in the same cycle. Phase B rises 10% of a period after phase A falls, and phase A rises 10% of a period after phase B falls (10 or 2 cycles in each case).
- R4: While enabled, the pattern repeats without a gap. Successive rising edges of phase A are exactly one period apart: 100 cycles in linear mode, 20 in decade mode.
- R5: A synchronous active-high reset clears the counter and the half toggle, and holds both phases and the strobe low. This applies both during reset and in the cycle that follows it. After reset is released with enable high, phase A is high after the first clock edge.
- R6: While enable is low, the counter holds its position and both phases and the strobe are low from the next edge onward. When enable returns, counting resumes from the held position. Each phase stays low until its own start position is next reached.
- R7: The wrap strobe is high for exactly one cycle after the counter passes its last position (count 99, or half 1 with digit 9). Phase A rises in the cycle right after the strobe.
- R8: With DECADE=1 the period is 20 cycles. The decade digit 0–9 is qualified by the half toggle, so that the edge positions 0, 9, 11 and 18 give the same 45%/35% pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, one count step per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Count enable; when low, the outputs are forced low and the counter holds |
| phase_a_o | output | 1 | First gate-drive phase, 45% duty |
| phase_b_o | output | 1 | Second gate-drive phase, 35% duty, inside the low time of phase A |
| period_wrap_o | output | 1 | One-cycle strobe when the counter returns to zero |

## Verification
The bench builds two copies of the block side by side. One uses the default linear 100-step counter. The other sets DECADE=1, which selects the decade counter with its half toggle, so the toggle-qualified decode runs under the same stimulus. The short 20-cycle period of the decade copy lets many periods, wraps and phase-gap measurements fit into each run. The 100-step copy exercises the wide counter's wrap at 99 and the resume from a held position in the middle of a pulse.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

  // Edge positions as percent of one output period
  localparam int PCT_A_ON  = 0;
  localparam int PCT_A_OFF = 45;
  localparam int PCT_B_ON  = 55;
  localparam int PCT_B_OFF = 90;

  // Decade variant constants
  localparam int DECADE_STEPS = 20;
  localparam int DIGIT_W      = 4;
  localparam int DIGIT_LAST   = 9;

  // Number of decoded edges (set/clear for each of two phases)
  localparam int N_EDGES = 4;

  function automatic int edge_at(input int steps, input int pct);
    return (steps * pct) / 100;
  endfunction

endpackage

// File: rtl/phase_counter.sv
module phase_counter
  import twophase_pkg::*;
#(
  parameter bit DECADE = 1'b0,
  parameter int STEPS  = 100,
  parameter int CW     = 7
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o,
  output logic          half_o,
  output logic          last_o
);

  localparam logic [CW-1:0] TERM_LIN = CW'(STEPS - 1);
  localparam logic [CW-1:0] TERM_DIG = CW'(DIGIT_LAST);

  logic [CW-1:0] cnt_q;

  generate
    if (DECADE) begin : g_decade
      logic half_q;

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q  <= '0;
          half_q <= 1'b0;
        end else if (en_i) begin
          if (cnt_q == TERM_DIG) begin
            cnt_q  <= '0;
            half_q <= ~half_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end

      assign half_o = half_q;
      assign last_o = half_q && (cnt_q == TERM_DIG);
    end else begin : g_linear
      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          cnt_q <= '0;
        end else if (en_i) begin
          if (cnt_q == TERM_LIN) cnt_q <= '0;
          else                   cnt_q <= cnt_q + 1'b1;
        end
      end

      assign half_o = 1'b0;
      assign last_o = (cnt_q == TERM_LIN);
    end
  endgenerate

  assign cnt_o = cnt_q;

endmodule

// File: rtl/edge_decode.sv
module edge_decode #(
  parameter bit DECADE = 1'b0,
  parameter int CW     = 7,
  parameter int POS    = 0
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          half_i,
  output logic          hit_o
);

  generate
    if (DECADE) begin : g_decade
      localparam int            HALF_SEL = POS / 10;
      localparam logic [CW-1:0] DIG      = CW'(POS % 10);
      assign hit_o = (half_i == 1'(HALF_SEL)) && (cnt_i == DIG);
    end else begin : g_linear
      localparam logic [CW-1:0] LIN = CW'(POS);
      assign hit_o = (cnt_i == LIN);
    end
  endgenerate

endmodule

// File: rtl/setclr_flop.sv
module setclr_flop (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) q_o <= 1'b0;
    else if (set_i)     q_o <= 1'b1;
    else if (clr_i)     q_o <= 1'b0;
  end

endmodule

// File: rtl/twophase_gen.sv
module twophase_gen
  import twophase_pkg::*;
#(
  parameter bit DECADE    = 1'b0,
  parameter int LIN_STEPS = 100
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic phase_a_o,
  output logic phase_b_o,
  output logic period_wrap_o
);

  localparam int STEPS = DECADE ? DECADE_STEPS : LIN_STEPS;
  localparam int CW    = DECADE ? DIGIT_W : $clog2(LIN_STEPS);

  // Edge order: A set, A clear, B set, B clear
  localparam int POS [N_EDGES] = '{
    edge_at(STEPS, PCT_A_ON),
    edge_at(STEPS, PCT_A_OFF),
    edge_at(STEPS, PCT_B_ON),
    edge_at(STEPS, PCT_B_OFF)
  };

  logic [CW-1:0]      cnt;
  logic               half;
  logic               last;
  logic [N_EDGES-1:0] hit;
  logic               wrap_q;

  phase_counter #(
    .DECADE(DECADE),
    .STEPS (STEPS),
    .CW    (CW)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .cnt_o (cnt),
    .half_o(half),
    .last_o(last)
  );

  generate
    for (genvar i = 0; i < N_EDGES; i++) begin : g_edge
      edge_decode #(
        .DECADE(DECADE),
        .CW    (CW),
        .POS   (POS[i])
      ) u_dec (
        .cnt_i (cnt),
        .half_i(half),
        .hit_o (hit[i])
      );
    end
  endgenerate

  setclr_flop u_phase_a (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .en_i (en_i),
    .set_i(hit[0]),
    .clr_i(hit[1]),
    .q_o  (phase_a_o)
  );

  setclr_flop u_phase_b (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .en_i (en_i),
    .set_i(hit[2]),
    .clr_i(hit[3]),
    .q_o  (phase_b_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) wrap_q <= 1'b0;
    else       wrap_q <= en_i && last;
  end

  assign period_wrap_o = wrap_q;

endmodule

// File: rtl/twophase_gen_chk.sv
module twophase_gen_chk #(
  parameter int HI_A = 45,
  parameter int HI_B = 35
) (
  input logic clk_i,
  input logic rst_i,
  input logic en_i,
  input logic pa,
  input logic pb,
  input logic wrap
);

  logic rst_q = 1'b0;
  int   run_a;
  int   run_b;

  always_ff @(posedge clk_i) begin
    rst_q <= rst_i;
    if (rst_i) begin
      run_a <= 0;
      run_b <= 0;
    end else begin
      run_a <= pa ? run_a + 1 : 0;
      run_b <= pb ? run_b + 1 : 0;
    end
  end

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !(pa && pb));

  assert_run_a_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    pa |-> (run_a < HI_A));

  assert_run_b_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    pb |-> (run_b < HI_B));

  assert_reset_low_R5: assert property (@(posedge clk_i)
    rst_q |-> (!pa && !pb && !wrap));

  assert_disable_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (!pa && !pb && !wrap));

  assert_wrap_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap |=> !wrap);

  assert_wrap_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap && en_i) |=> pa);

endmodule

bind twophase_gen twophase_gen_chk #(
  .HI_A(POS[1] - POS[0]),
  .HI_B(POS[3] - POS[2])
) u_chk (
  .clk_i(clk_i),
  .rst_i(rst_i),
  .en_i (en_i),
  .pa   (phase_a_o),
  .pb   (phase_b_o),
  .wrap (period_wrap_o)
);

// File: tb/twophase_gen_bench.sv
`timescale 1ns/1ps
module twophase_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  always #5 clk = ~clk;

  logic b_a, b_b, b_w, d_a, d_b, d_w;

  twophase_gen u_twophase_gen (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .phase_a_o(b_a), .phase_b_o(b_b), .period_wrap_o(b_w)
  );

  twophase_gen #(.DECADE(1'b1)) u_twophase_gen_dec (
    .clk_i(clk), .rst_i(rst), .en_i(en),
    .phase_a_o(d_a), .phase_b_o(d_b), .period_wrap_o(d_w)
  );

  int n_chk = 0;
  int n_err = 0;

  // Mode 0: linear 100 steps; mode 1: decade 20 steps
  int S_T  [2] = '{100, 20};
  int E1_T [2] = '{45, 9};
  int E2_T [2] = '{55, 11};
  int E3_T [2] = '{90, 18};

  // reference model
  int m_ph [2];
  bit m_a [2], m_b [2], m_w [2];
  int mm [2];

  // waveform tracking
  bit trk = 1'b0;
  int cyc = 0;
  bit p_a [2], p_b [2], p_w [2];
  int t_rise_a [2], t_fall_a [2], t_rise_b [2], t_fall_b [2];
  int n_rise_a [2], n_wrap [2];
  int bad_len_a [2], bad_len_b [2], bad_gap [2], bad_per [2], bad_ovl [2], bad_wrap [2];

  function automatic logic out_a(int m); return (m == 1) ? d_a : b_a; endfunction
  function automatic logic out_b(int m); return (m == 1) ? d_b : b_b; endfunction
  function automatic logic out_w(int m); return (m == 1) ? d_w : b_w; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic track_clear();
    for (int m = 0; m < 2; m++) begin
      p_a[m] = 0; p_b[m] = 0; p_w[m] = 0;
      t_rise_a[m] = -1; t_fall_a[m] = -1; t_rise_b[m] = -1; t_fall_b[m] = -1;
      n_rise_a[m] = 0; n_wrap[m] = 0;
      bad_len_a[m] = 0; bad_len_b[m] = 0; bad_gap[m] = 0;
      bad_per[m] = 0; bad_ovl[m] = 0; bad_wrap[m] = 0;
      mm[m] = 0;
    end
  endtask

  // Drive inputs at a falling edge, let one rising edge pass, sample at next falling edge
  task automatic tick(input bit r, input bit e);
    rst = r;
    en  = e;
    @(negedge clk);
    cyc++;
    for (int m = 0; m < 2; m++) begin
      logic ca, cb, cw;
      if (r) begin
        m_ph[m] = 0; m_a[m] = 0; m_b[m] = 0; m_w[m] = 0;
      end else if (!e) begin
        m_a[m] = 0; m_b[m] = 0; m_w[m] = 0;
      end else begin
        m_w[m] = (m_ph[m] == S_T[m] - 1);
        if (m_ph[m] == 0)          m_a[m] = 1;
        else if (m_ph[m] == E1_T[m]) m_a[m] = 0;
        if (m_ph[m] == E2_T[m])      m_b[m] = 1;
        else if (m_ph[m] == E3_T[m]) m_b[m] = 0;
        m_ph[m] = (m_ph[m] + 1) % S_T[m];
      end
      ca = out_a(m); cb = out_b(m); cw = out_w(m);
      if (ca !== m_a[m] || cb !== m_b[m] || cw !== m_w[m]) mm[m]++;
      if (trk) begin
        if (ca && cb) bad_ovl[m]++;
        if ((n_rise_a[m] > 0 || p_w[m]) && (p_w[m] != (ca && !p_a[m]))) bad_wrap[m]++;
        if (cw) begin
          n_wrap[m]++;
          if (p_w[m]) bad_wrap[m]++;
        end
        if (ca && !p_a[m]) begin
          if (n_rise_a[m] > 0 && (cyc - t_rise_a[m]) != S_T[m]) bad_per[m]++;
          if (t_fall_b[m] >= 0 && (cyc - t_fall_b[m]) != S_T[m] - E3_T[m]) bad_gap[m]++;
          t_rise_a[m] = cyc;
          n_rise_a[m]++;
        end
        if (!ca && p_a[m]) begin
          if ((cyc - t_rise_a[m]) != E1_T[m]) bad_len_a[m]++;
          t_fall_a[m] = cyc;
        end
        if (cb && !p_b[m]) begin
          if (t_fall_a[m] < 0 || (cyc - t_fall_a[m]) != E2_T[m] - E1_T[m]) bad_gap[m]++;
          t_rise_b[m] = cyc;
        end
        if (!cb && p_b[m]) begin
          if (t_rise_b[m] < 0 || (cyc - t_rise_b[m]) != E3_T[m] - E2_T[m]) bad_len_b[m]++;
          t_fall_b[m] = cyc;
        end
      end
      p_a[m] = ca; p_b[m] = cb; p_w[m] = cw;
    end
  endtask

  // R5: reset state and first counted cycle
  task automatic test_reset();
    track_clear();
    for (int i = 0; i < 4; i++) tick(1, 1);
    for (int m = 0; m < 2; m++)
      chk(!out_a(m) && !out_b(m) && !out_w(m), "R5", "outputs low in reset",
          int'({out_a(m), out_b(m), out_w(m)}), 0);
    tick(0, 1);
    for (int m = 0; m < 2; m++) begin
      chk(out_a(m) == 1'b1, "R5", "phase A high after first edge", int'(out_a(m)), 1);
      chk(out_b(m) == 1'b0, "R5", "phase B low after first edge", int'(out_b(m)), 0);
    end
  endtask

  // R1 R2 R3 R4 R7 R8: continuous run over several periods
  task automatic test_steady();
    tick(1, 1); tick(1, 1);
    track_clear();
    trk = 1'b1;
    for (int i = 0; i < 300; i++) tick(0, 1);
    trk = 1'b0;
    for (int m = 0; m < 2; m++) begin
      chk(mm[m] == 0, "R4", "waveform vs model mismatches", mm[m], 0);
      chk(bad_len_a[m] == 0, "R1", "phase A high-length errors", bad_len_a[m], 0);
      chk(bad_len_b[m] == 0, "R2", "phase B high-length errors", bad_len_b[m], 0);
      chk(bad_ovl[m] == 0, "R3", "overlap cycles", bad_ovl[m], 0);
      chk(bad_gap[m] == 0, "R3", "guard gap errors", bad_gap[m], 0);
      chk(bad_per[m] == 0 && n_rise_a[m] == 300 / S_T[m], "R4", "phase A rising edges",
          n_rise_a[m] - bad_per[m], 300 / S_T[m]);
      chk(bad_wrap[m] == 0 && n_wrap[m] == 300 / S_T[m], "R7", "wrap strobes",
          n_wrap[m] - bad_wrap[m], 300 / S_T[m]);
    end
    chk(n_rise_a[1] == 15 && bad_len_a[1] == 0 && bad_len_b[1] == 0, "R8",
        "decade mode periods in 300 cycles", n_rise_a[1], 15);
  endtask

  // R6: disable while phase A high, then resume from held position
  task automatic test_enable_a();
    tick(1, 1);
    track_clear();
    for (int i = 0; i < 20; i++) tick(0, 1);
    begin
      int hi [2] = '{0, 0};
      for (int i = 0; i < 7; i++) begin
        tick(0, 0);
        for (int m = 0; m < 2; m++)
          if (out_a(m) || out_b(m) || out_w(m)) hi[m]++;
      end
      for (int m = 0; m < 2; m++)
        chk(hi[m] == 0, "R6", "outputs high while disabled (A window)", hi[m], 0);
    end
    for (int i = 0; i < 120; i++) tick(0, 1);
    for (int m = 0; m < 2; m++)
      chk(mm[m] == 0, "R6", "resume from held position mismatches", mm[m], 0);
  endtask

  // R6: disable while phase B high
  task automatic test_enable_b();
    tick(1, 1);
    track_clear();
    for (int i = 0; i < 60; i++) tick(0, 1);
    chk(out_b(0) == 1'b1, "R2", "phase B high at count 60 before disable", int'(out_b(0)), 1);
    begin
      int hi [2] = '{0, 0};
      for (int i = 0; i < 3; i++) begin
        tick(0, 0);
        for (int m = 0; m < 2; m++)
          if (out_a(m) || out_b(m) || out_w(m)) hi[m]++;
      end
      for (int m = 0; m < 2; m++)
        chk(hi[m] == 0, "R6", "outputs high while disabled (B window)", hi[m], 0);
    end
    tick(0, 1);
    chk(out_b(0) == 1'b0, "R6", "phase B stays low after resume", int'(out_b(0)), 0);
    for (int i = 0; i < 150; i++) tick(0, 1);
    for (int m = 0; m < 2; m++)
      chk(mm[m] == 0, "R6", "resume mid-B mismatches", mm[m], 0);
  endtask

  // R5: reset in the middle of a period
  task automatic test_reset_mid();
    tick(1, 1);
    track_clear();
    for (int i = 0; i < 50; i++) tick(0, 1);
    tick(1, 1);
    for (int m = 0; m < 2; m++)
      chk(!out_a(m) && !out_b(m) && !out_w(m), "R5", "outputs low after mid-run reset",
          int'({out_a(m), out_b(m), out_w(m)}), 0);
    for (int i = 0; i < 120; i++) tick(0, 1);
    for (int m = 0; m < 2; m++)
      chk(mm[m] == 0, "R5", "restart after mid-run reset mismatches", mm[m], 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_steady();
    test_enable_a();
    test_enable_b();
    test_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule